// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one PWM reference into a pair of complementary drive signals for a half bridge. The main output follows the reference and the complementary output follows its inverse. Before either output is allowed to go high, it waits a programmable dead time after its own phase began. The two switches therefore never conduct together.

The dead time is counted in ticks of a clock enable, `tick_en`. An 8-bit code picks the dead time. The top bits of the code select one of four segments, and each segment has its own base value and multiplier. This gives fine steps for short delays and coarse steps for long delays, up to 1008 ticks. An output goes low in the same time step as the reference edge that ends its phase. Each output also has its own enable.

Top module: `pwm_deadband`

## Requirements
- R1: When dt_code[7] is 0, the dead time N in ticks equals dt_code (0 to 127).
- R2: When dt_code[7:6] is 2'b10, N = 2 * (64 + dt_code[5:0]), giving 128 to 254.
- R3: When dt_code[7:5] is 3'b110, N = 8 * (32 + dt_code[4:0]), giving 256 to 504.
- R4: When dt_code[7:5] is 3'b111, N = 16 * (32 + dt_code[4:0]), giving 512 to 1008.
- R5: After ref_in rises, main_out goes high just after the N-th rising clock edge at which tick_en is 1. Counting starts with the first edge at which ref_in is seen high. Edges with tick_en at 0 do not advance the count.
- R6: After ref_in falls, comp_out goes high just after the N-th tick-enabled edge, counted in the same way as in R5.
- R7: main_out goes low in the same time step as a falling edge of ref_in. comp_out goes low in the same time step as a rising edge of ref_in. Neither waits for a clock edge.
- R8: If a phase of ref_in lasts fewer than N tick-enabled edges, the output belonging to that phase stays low for the whole phase.
- R9: With dt_code equal to 0, main_out equals ref_in and comp_out equals its inverse, with no gap between them.
- R10: When main_en or comp_en is 0, the matching output is held low. The other output keeps its normal timing.
- R11: main_out and comp_out are never high at the same time.
- R12: While rst_n is low and dt_code is nonzero, both outputs are low whatever the level of ref_in. Internal reset is released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Dead-time tick; one count per clock edge at which it is high |
| ref_in | input | 1 | PWM reference |
| dt_code | input | 8 | Segmented dead-time code |
| main_en | input | 1 | Enable for main_out |
| comp_en | input | 1 | Enable for comp_out |
| main_out | output | 1 | Main drive, follows ref_in after the dead time |
| comp_out | output | 1 | Complementary drive, follows the inverse of ref_in after the dead time |

## Verification
Falling outputs are due zero cycles after the reference edge, so the bench checks them one time unit after it drives the edge. A rising output is due just after the N-th tick-enabled edge, counted from the first edge at which the new reference level is present. The bench drives `tick_en` itself and counts each edge at which it held the tick high. It samples the outputs at the falling clock edge and compares the tick count at the first high sample with the decoded N. Its cases include codes on both sides of every segment boundary, a sparse tick pattern, phases that are too short, and disabled outputs.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
  localparam int CODE_W = 8;
  localparam int DT_W   = 10;  // holds the largest delay, 1008 ticks

  // Piecewise decode: each segment becomes a shifted concatenation, so no multiplier is needed
  function automatic logic [DT_W-1:0] dt_from_code(input logic [CODE_W-1:0] c);
    logic [DT_W-1:0] r;
    if (!c[7])      r = DT_W'(c);                            // linear, 1x
    else if (!c[6]) r = DT_W'({1'b1, c[5:0], 1'b0});         // 128 + 2*x
    else if (!c[5]) r = DT_W'({1'b1, c[4:0], 3'b000});       // 256 + 8*x
    else            r = DT_W'({1'b1, c[4:0], 4'b0000});      // 512 + 16*x
    return r;
  endfunction
endpackage

// File: rtl/pwm_db_decode.sv
module pwm_db_decode
  import pwm_db_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic [DT_W-1:0]   dt_ticks
);
  always_comb dt_ticks = dt_from_code(code);

  // R1 R2 R3 R4: every segment maps to at least the code value itself
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    dt_ticks >= DT_W'(code))
    else $error("decode below code value");

  // R4: ceiling of the coarsest segment
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    dt_ticks <= DT_W'(1008))
    else $error("decode above ceiling");
endmodule

// File: rtl/pwm_db_channel.sv
module pwm_db_channel #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             src,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] dt_ticks,
  output logic             chan_out
);
  logic             src_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise, reached, dt_zero;

  always_comb begin
    rise    = src & ~src_q;
    reached = (cnt_q >= dt_ticks);
    dt_zero = (dt_ticks == '0);
  end

  // Elapsed-tick counter; it counts up only while the phase is active and not yet expired
  always_comb begin
    cnt_d = cnt_q;
    if (!src)                      cnt_d = '0;
    else if (rise)                 cnt_d = tick_en ? CNT_W'(1) : '0;
    else if (tick_en && !reached)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      src_q <= src;
      cnt_q <= cnt_d;
    end
  end

  // The output drops together with src; it rises only after the count has expired
  always_comb chan_out = chan_en & src & (dt_zero | (~rise & reached));

  // R8: no output in the first cycle of a phase while a nonzero delay is set
  a_r8_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !dt_zero) |-> !chan_out)
    else $error("output high on phase start");

  // R5 R6: without a tick the elapsed count holds
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (src && src_q && !tick_en) |=> (cnt_q == $past(cnt_q)))
    else $error("count moved without tick");
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_db_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ref_in,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              main_en,
  input  logic              comp_en,
  output logic              main_out,
  output logic              comp_out
);
  localparam int NCH = 2;

  logic [1:0]      rst_sync_q;
  logic            core_rst_n;
  logic [DT_W-1:0] dt_ticks;
  logic [NCH-1:0]  src_v, en_v, out_v;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb core_rst_n = rst_sync_q[1];

  pwm_db_decode u_decode (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .code     (dt_code),
    .dt_ticks (dt_ticks)
  );

  always_comb begin
    src_v = {~ref_in, ref_in};
    en_v  = {comp_en, main_en};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_db_channel #(.CNT_W(DT_W)) u_ch (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .tick_en  (tick_en),
      .src      (src_v[g]),
      .chan_en  (en_v[g]),
      .dt_ticks (dt_ticks),
      .chan_out (out_v[g])
    );
  end

  always_comb begin
    main_out = out_v[0];
    comp_out = out_v[1];
  end

  // R11: the two drive outputs never overlap
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(main_out && comp_out))
    else $error("both outputs high");

  // R7: an output that was high is low once its phase has ended
  a_r7_fall_with_ref: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(ref_in) |-> !main_out)
    else $error("main output held past reference fall");
endmodule

// File: tb/sim_pwm_deadband.sv
module sim_pwm_deadband;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       ref_in;
  logic [7:0] dt_code;
  logic       main_en, comp_en;
  logic       main_out, comp_out;

  int n_chk = 0;
  int n_bad = 0;

  // {code, expected ticks}
  localparam logic [17:0] VEC [12] = '{
    {8'h00, 10'd0},   {8'h01, 10'd1},   {8'h7F, 10'd127}, {8'h80, 10'd128},
    {8'h81, 10'd130}, {8'hBF, 10'd254}, {8'hC0, 10'd256}, {8'hC1, 10'd264},
    {8'hDF, 10'd504}, {8'hE0, 10'd512}, {8'hE1, 10'd528}, {8'hFF, 10'd1008}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_deadband u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_in(ref_in),
    .dt_code(dt_code), .main_en(main_en), .comp_en(comp_en),
    .main_out(main_out), .comp_out(comp_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string seg_req(input logic [7:0] c);
    if (!c[7]) return "R1";
    if (!c[6]) return "R2";
    if (!c[5]) return "R3";
    return "R4";
  endfunction

  // Drive a reference edge and count tick-enabled edges until the output of the new phase rises
  task automatic run_edge(input logic new_ref, input int per, input int exp,
                          input string req, output int cyc_out);
    int   ticks = 0;
    int   cyc   = 0;
    bit   overlap = 0;
    logic seen;
    ref_in = new_ref;
    #1;
    if (new_ref) check(comp_out == 1'b0, "R7", comp_out, 0, "comp_out low at ref rise");
    else         check(main_out == 1'b0, "R7", main_out, 0, "main_out low at ref fall");
    seen = new_ref ? main_out : comp_out;
    while (!seen && cyc < 3000) begin
      tick_en = ((cyc % per) == 0);
      @(posedge clk);
      if (tick_en) ticks++;
      cyc++;
      @(negedge clk);
      if (main_out && comp_out) overlap = 1;
      seen = new_ref ? main_out : comp_out;
    end
    tick_en = 1'b0;
    check(ticks == exp, req, ticks, exp, new_ref ? "main rise ticks (R5)" : "comp rise ticks (R6)");
    check(!overlap, "R11", overlap, 0, "outputs overlapped");
    cyc_out = cyc;
  endtask

  // Hold the current reference level for some cycles and confirm one output never rises
  task automatic hold_low(input int cycles, input bit watch_main, input string req);
    bit rose = 0;
    for (int k = 0; k < cycles; k++) begin
      tick_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (watch_main ? main_out : comp_out) rose = 1;
    end
    tick_en = 1'b0;
    check(!rose, req, rose, 0, watch_main ? "main_out stayed low" : "comp_out stayed low");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R0: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; tick_en = 1'b0; ref_in = 1'b1; dt_code = 8'h10;
    main_en = 1'b1; comp_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(main_out == 1'b0, "R12", main_out, 0, "main_out in reset, ref high");
    check(comp_out == 1'b0, "R12", comp_out, 0, "comp_out in reset, ref high");
    ref_in = 1'b0;
    #1;
    check(comp_out == 1'b0, "R12", comp_out, 0, "comp_out in reset, ref low");
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // Segment table, both edges for each code
    for (int i = 0; i < 12; i++) begin
      dt_code = VEC[i][17:10];
      run_edge(1'b1, 1, int'(VEC[i][9:0]), seg_req(dt_code), c);
      if (dt_code == 8'h00)
        check(main_out == ~comp_out, "R9", main_out, int'(~comp_out), "exact complement, ref high");
      run_edge(1'b0, 1, int'(VEC[i][9:0]), seg_req(dt_code), c);
      if (dt_code == 8'h00)
        check(main_out == ~comp_out, "R9", main_out, int'(~comp_out), "exact complement, ref low");
    end

    // Sparse ticks: one tick every third clock
    dt_code = 8'd5;
    run_edge(1'b1, 3, 5, "R5", c);
    check(c == 13, "R5", c, 13, "clocks to main rise with sparse ticks");
    run_edge(1'b0, 3, 5, "R6", c);
    check(c == 13, "R6", c, 13, "clocks to comp rise with sparse ticks");

    // Short phases
    dt_code = 8'd20;
    ref_in = 1'b1;
    hold_low(10, 1'b1, "R8");
    ref_in = 1'b0;
    hold_low(10, 1'b0, "R8");
    run_edge(1'b1, 1, 20, "R5", c);
    run_edge(1'b0, 1, 20, "R6", c);

    // Enables
    dt_code = 8'd3;
    main_en = 1'b0;
    ref_in  = 1'b1;
    hold_low(12, 1'b1, "R10");
    run_edge(1'b0, 1, 3, "R10", c);
    main_en = 1'b1;
    comp_en = 1'b0;
    run_edge(1'b1, 1, 3, "R10", c);
    ref_in = 1'b0;
    hold_low(12, 1'b0, "R10");
    comp_en = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule